// File: doc/BRIEF.md
# Color Palette Host Access Port

This block is the host-side register port of a 256-entry color lookup memory. Each entry is a 30-bit word made of three 10-bit components: red, green and blue. A two-bit target select picks one of four destinations: the address register, the palette data, an indirectly indexed bank of control registers, or the mode register. Every access is qualified by a chip enable, carries a read/write flag, and is completed by a single-cycle strobe.

Palette traffic moves in component triplets. An internal pointer steps red, green, blue with each palette access. After blue it returns to red and the address register advances by one, wrapping from the top index to zero. Writing the address register also sends the pointer back to red. On a write, red and green wait in staging registers, and the whole word goes into the memory together with blue. Control registers are reached by loading their index into the address register and then accessing the control target. Mode bit 0 switches palette transfers to an 8-bit form that moves the upper eight bits of each component.

Top module: `clut_host_port`

## Requirements
- R1: After synchronous reset, rdata is 0, the address register is 0, the mode register is 0, the pointer is at red, the pixel mask control register (index 08h) holds FFh and all other writable control registers hold 0.
- R2: With the address set to N, three palette writes store red, green and blue of location N, and three palette reads return them in the order red, green, blue. The memory word is written only on the blue write.
- R3: The component pointer advances on every palette access, returns to red after blue, and returns to red whenever the address register is written.
- R4: The address register increments by one after each blue palette access, read or write. Control, mode and address reads leave it unchanged.
- R5: A blue palette access at address FFh leaves the address register at 00h.
- R6: Select encoding is 00 address register, 01 palette, 10 control register, 11 mode register. rdata takes the read value at the second rising edge counting the edge that samples the read strobe, and holds it until the next read.
- R7: Control registers at indices 03h–05h and 08h–0Bh take wdata[7:0] on a control write and return it, zero-extended, on a control read. wdata[9:8] is ignored.
- R8: Indices 00h–02h and 0Ch–FFh read as 0, index 06h reads the revision code (default 0Ah) and index 07h reads the ID code (default 3Ah). Writes to any of these indices have no effect.
- R9: The mode register is 8 bits wide, written from wdata[7:0] and read back zero-extended. Its bit 0 set selects 8-bit palette transfers.
- R10: In 8-bit mode a palette write stores {wdata[7:0], 2'b00} as the component, and a palette read returns the component's bits 9:2 on rdata[7:0] with rdata[9:8] zero.
- R11: An access with cs low, or with strobe low, changes no register and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip enable, qualifies the strobe |
| strobe | input | 1 | Single-cycle access strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| sel | input | 2 | Target select (see R6) |
| wdata | input | 10 | Write data |
| rdata | output | 10 | Registered read data |

## Verification
A pointer that drifts out of step shows up at once: the next palette read returns the wrong component. A stuck or early address increment shows up as a wrong value on the following address read, or as a whole triplet coming back from the neighbouring location. A decode fault in the control bank appears on the very next control read of the affected index, either as a read-only value that is no longer zero or constant or as a writable value that fails to read back. Because rdata holds between reads, any corruption of the read pipeline is visible two edges after the offending strobe.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_PAL  = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_MODE = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    C_RED   = 2'd0,
    C_GREEN = 2'd1,
    C_BLUE  = 2'd2
  } comp_e;
endpackage

// File: rtl/clut_ptr_seq.sv
module clut_ptr_seq
  import clut_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              pal_step,
  output logic [ADDR_W-1:0] addr,
  output comp_e             comp
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      comp <= C_RED;
    end else if (addr_we) begin
      addr <= addr_wdata;
      comp <= C_RED;
    end else if (pal_step) begin
      case (comp)
        C_RED:   comp <= C_GREEN;
        C_GREEN: comp <= C_BLUE;
        default: begin
          comp <= C_RED;
          addr <= addr + 1'b1;
        end
      endcase
    end
  end

  // R3
  ptr_reload_chk: assert property (@(posedge clk) disable iff (rst)
    addr_we |=> (comp == C_RED));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pal_step && !addr_we && comp == C_BLUE) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_we && !(pal_step && comp == C_BLUE)) |=> $stable(addr));

endmodule

// File: rtl/clut_palette_ram.sv
module clut_palette_ram
  import clut_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COMP_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_step,
  input  logic                rd_step,
  input  logic [ADDR_W-1:0]   addr,
  input  comp_e               comp,
  input  logic [COMP_W-1:0]   wcomp,
  output logic [3*COMP_W-1:0] rword
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 3 * COMP_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [COMP_W-1:0] red_q;
  logic [COMP_W-1:0] grn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      red_q <= '0;
      grn_q <= '0;
    end else if (wr_step) begin
      if (comp == C_RED)   red_q <= wcomp;
      if (comp == C_GREEN) grn_q <= wcomp;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_step && comp == C_BLUE) mem[addr] <= {red_q, grn_q, wcomp};
    if (rd_step) rword <= mem[addr];
  end

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_step || comp == C_BLUE) |=> ($stable(red_q) && $stable(grn_q)));

endmodule

// File: rtl/clut_ctrl_regs.sv
module clut_ctrl_regs #(
  parameter int               IDX_W    = 8,
  parameter int               REG_W    = 8,
  parameter int               NUM_IDX  = 12,
  parameter logic [REG_W-1:0] REV_VAL  = 8'h0A,
  parameter logic [REG_W-1:0] ID_VAL   = 8'h3A,
  parameter logic [REG_W-1:0] MASK_RST = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_val
);

  localparam int               LIDX     = $clog2(NUM_IDX);
  localparam int               MASK_I   = 8;
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(NUM_IDX - 1);
  localparam logic [IDX_W-1:0] TST_LO   = IDX_W'(3);
  localparam logic [IDX_W-1:0] TST_HI   = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_REV  = IDX_W'(6);
  localparam logic [IDX_W-1:0] IDX_ID   = IDX_W'(7);
  localparam logic [IDX_W-1:0] CMD_LO   = IDX_W'(MASK_I);

  logic [NUM_IDX-1:0][REG_W-1:0] cr;

  function automatic logic is_wr(input logic [IDX_W-1:0] k);
    return (k >= TST_LO && k <= TST_HI) || (k >= CMD_LO && k <= LAST);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IDX; i++) cr[i] <= (i == MASK_I) ? MASK_RST : '0;
    end else if (we && is_wr(idx)) begin
      cr[idx[LIDX-1:0]] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (is_wr(idx))          rd_val = cr[idx[LIDX-1:0]];
    else if (idx == IDX_REV) rd_val = REV_VAL;
    else if (idx == IDX_ID)  rd_val = ID_VAL;
  end

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !is_wr(idx)) |=> $stable(cr));

endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
  import clut_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               COMP_W    = 10,
  parameter int               REG_W     = 8,
  parameter int               NUM_CTRL  = 12,
  parameter logic [REG_W-1:0] REV_CODE  = 8'h0A,
  parameter logic [REG_W-1:0] ID_CODE   = 8'h3A,
  parameter logic [REG_W-1:0] MASK_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              strobe,
  input  logic              rd_nwr,
  input  logic [1:0]        sel,
  input  logic [COMP_W-1:0] wdata,
  output logic [COMP_W-1:0] rdata
);

  localparam int NARROW_W = 8;
  localparam int PAD_W    = COMP_W - NARROW_W;

  sel_e                sel_t;
  logic                go, rd_go, wr_go;
  logic                addr_we, pal_step, ctrl_we;
  logic [ADDR_W-1:0]   addr;
  comp_e               comp;
  logic [REG_W-1:0]    mode_q;
  logic [COMP_W-1:0]   wcomp;
  logic [3*COMP_W-1:0] rword;
  logic [REG_W-1:0]    ctrl_val;

  logic                s_rd, s_narrow;
  sel_e                s_sel;
  comp_e               s_comp;
  logic [COMP_W-1:0]   s_val;
  logic [COMP_W-1:0]   pcomp, pout;

  assign sel_t    = sel_e'(sel);
  assign go       = cs && strobe;
  assign rd_go    = go && rd_nwr;
  assign wr_go    = go && !rd_nwr;
  assign addr_we  = wr_go && sel_t == SEL_ADDR;
  assign pal_step = go && sel_t == SEL_PAL;
  assign ctrl_we  = wr_go && sel_t == SEL_CTRL;
  assign wcomp    = mode_q[0] ? {wdata[NARROW_W-1:0], {PAD_W{1'b0}}} : wdata;

  clut_ptr_seq #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .addr_we(addr_we), .addr_wdata(wdata[ADDR_W-1:0]),
    .pal_step(pal_step), .addr(addr), .comp(comp)
  );

  clut_palette_ram #(.ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_ram (
    .clk(clk), .rst(rst), .wr_step(pal_step && !rd_nwr), .rd_step(pal_step && rd_nwr),
    .addr(addr), .comp(comp), .wcomp(wcomp), .rword(rword)
  );

  clut_ctrl_regs #(
    .IDX_W(ADDR_W), .REG_W(REG_W), .NUM_IDX(NUM_CTRL),
    .REV_VAL(REV_CODE), .ID_VAL(ID_CODE), .MASK_RST(MASK_INIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .idx(addr),
    .wdata(wdata[REG_W-1:0]), .rd_val(ctrl_val)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (wr_go && sel_t == SEL_MODE) mode_q <= wdata[REG_W-1:0];
  end

  // first read stage: capture target, pointer and register value
  always_ff @(posedge clk) begin
    if (rst) begin
      s_rd     <= 1'b0;
      s_sel    <= SEL_ADDR;
      s_comp   <= C_RED;
      s_narrow <= 1'b0;
      s_val    <= '0;
    end else begin
      s_rd <= rd_go;
      if (rd_go) begin
        s_sel    <= sel_t;
        s_comp   <= comp;
        s_narrow <= mode_q[0];
        case (sel_t)
          SEL_ADDR: s_val <= COMP_W'(addr);
          SEL_MODE: s_val <= COMP_W'(mode_q);
          SEL_CTRL: s_val <= COMP_W'(ctrl_val);
          default:  s_val <= '0;
        endcase
      end
    end
  end

  always_comb begin
    case (s_comp)
      C_RED:   pcomp = rword[3*COMP_W-1 -: COMP_W];
      C_GREEN: pcomp = rword[2*COMP_W-1 -: COMP_W];
      default: pcomp = rword[COMP_W-1:0];
    endcase
    pout = s_narrow ? COMP_W'(pcomp[COMP_W-1 -: NARROW_W]) : pcomp;
  end

  // second read stage: output register
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (s_rd) rdata <= (s_sel == SEL_PAL) ? pout : s_val;
  end

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_go, 2) |-> $stable(rdata));

  // R11
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(mode_q));

endmodule

// File: tb/clut_host_port_bench.sv
module clut_host_port_bench;
  localparam int CLK_NS = 8;
  localparam int NV     = 61;

  typedef logic [26:0] vec_t; // {rid[3:0], sel[1:0], rd, data[9:0], exp[9:0]}

  // A=0 address, P=1 palette, C=2 control, M=3 mode
  localparam vec_t VEC [NV] = '{
    {4'd2, 2'd0, 1'b0, 10'h010, 10'h000},  // R2 set address
    {4'd2, 2'd1, 1'b0, 10'h111, 10'h000},
    {4'd2, 2'd1, 1'b0, 10'h222, 10'h000},
    {4'd2, 2'd1, 1'b0, 10'h333, 10'h000},
    {4'd4, 2'd0, 1'b1, 10'h000, 10'h011},  // R4 increment after blue write
    {4'd6, 2'd0, 1'b0, 10'h010, 10'h000},
    {4'd2, 2'd1, 1'b1, 10'h000, 10'h111},  // R2 red
    {4'd2, 2'd1, 1'b1, 10'h000, 10'h222},  // R2 green
    {4'd2, 2'd1, 1'b1, 10'h000, 10'h333},  // R2 blue
    {4'd4, 2'd0, 1'b1, 10'h000, 10'h011},  // R4 increment after blue read
    {4'd5, 2'd0, 1'b0, 10'h0FF, 10'h000},
    {4'd5, 2'd1, 1'b0, 10'h3FF, 10'h000},
    {4'd5, 2'd1, 1'b0, 10'h000, 10'h000},
    {4'd5, 2'd1, 1'b0, 10'h155, 10'h000},
    {4'd5, 2'd0, 1'b1, 10'h000, 10'h000},  // R5 wrap on write
    {4'd5, 2'd0, 1'b0, 10'h0FF, 10'h000},
    {4'd3, 2'd1, 1'b1, 10'h000, 10'h3FF},
    {4'd3, 2'd0, 1'b0, 10'h0FF, 10'h000},  // R3 address write mid-triplet
    {4'd3, 2'd1, 1'b1, 10'h000, 10'h3FF},  // R3 back at red
    {4'd3, 2'd1, 1'b1, 10'h000, 10'h000},
    {4'd3, 2'd1, 1'b1, 10'h000, 10'h155},
    {4'd5, 2'd0, 1'b1, 10'h000, 10'h000},  // R5 wrap on read
    {4'd7, 2'd0, 1'b0, 10'h008, 10'h000},
    {4'd7, 2'd2, 1'b1, 10'h000, 10'h0FF},  // R7 pixel mask reset value
    {4'd7, 2'd2, 1'b0, 10'h05A, 10'h000},
    {4'd7, 2'd2, 1'b1, 10'h000, 10'h05A},
    {4'd4, 2'd0, 1'b1, 10'h000, 10'h008},  // R4 control access keeps address
    {4'd7, 2'd0, 1'b0, 10'h003, 10'h000},
    {4'd7, 2'd2, 1'b0, 10'h3FF, 10'h000},
    {4'd7, 2'd2, 1'b1, 10'h000, 10'h0FF},  // R7 upper bits ignored
    {4'd7, 2'd0, 1'b0, 10'h00B, 10'h000},
    {4'd7, 2'd2, 1'b0, 10'h0C3, 10'h000},
    {4'd7, 2'd2, 1'b1, 10'h000, 10'h0C3},
    {4'd8, 2'd0, 1'b0, 10'h007, 10'h000},
    {4'd8, 2'd2, 1'b0, 10'h033, 10'h000},
    {4'd8, 2'd2, 1'b1, 10'h000, 10'h03A},  // R8 ID unchanged
    {4'd8, 2'd0, 1'b0, 10'h006, 10'h000},
    {4'd8, 2'd2, 1'b0, 10'h044, 10'h000},
    {4'd8, 2'd2, 1'b1, 10'h000, 10'h00A},  // R8 revision unchanged
    {4'd8, 2'd0, 1'b0, 10'h001, 10'h000},
    {4'd8, 2'd2, 1'b0, 10'h077, 10'h000},
    {4'd8, 2'd2, 1'b1, 10'h000, 10'h000},  // R8 reserved reads zero
    {4'd8, 2'd0, 1'b0, 10'h00C, 10'h000},
    {4'd8, 2'd2, 1'b0, 10'h011, 10'h000},
    {4'd8, 2'd2, 1'b1, 10'h000, 10'h000},  // R8 beyond map
    {4'd9, 2'd3, 1'b0, 10'h001, 10'h000},
    {4'd9, 2'd3, 1'b1, 10'h000, 10'h001},  // R9 mode readback
    {4'd10, 2'd0, 1'b0, 10'h010, 10'h000},
    {4'd10, 2'd1, 1'b1, 10'h000, 10'h044}, // R10 narrow reads
    {4'd10, 2'd1, 1'b1, 10'h000, 10'h088},
    {4'd10, 2'd1, 1'b1, 10'h000, 10'h0CC},
    {4'd10, 2'd0, 1'b0, 10'h020, 10'h000},
    {4'd10, 2'd1, 1'b0, 10'h0AB, 10'h000}, // R10 narrow writes
    {4'd10, 2'd1, 1'b0, 10'h3CD, 10'h000},
    {4'd10, 2'd1, 1'b0, 10'h0EF, 10'h000},
    {4'd9, 2'd3, 1'b0, 10'h000, 10'h000},
    {4'd10, 2'd0, 1'b0, 10'h020, 10'h000},
    {4'd10, 2'd1, 1'b1, 10'h000, 10'h2AC},
    {4'd10, 2'd1, 1'b1, 10'h000, 10'h334},
    {4'd10, 2'd1, 1'b1, 10'h000, 10'h3BC},
    {4'd6, 2'd3, 1'b1, 10'h000, 10'h000}   // R6 mode target readback
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       strobe = 1'b0;
  logic       rd_nwr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS / 2) clk = ~clk;

  clut_host_port u_clut_host_port (
    .clk(clk), .rst(rst), .cs(cs), .strobe(strobe), .rd_nwr(rd_nwr),
    .sel(sel), .wdata(wdata), .rdata(rdata)
  );

  task automatic acc(input logic c, input logic s, input logic [1:0] sl,
                     input logic r, input logic [9:0] d);
    @(negedge clk);
    cs = c; strobe = s; sel = sl; rd_nwr = r; wdata = d;
    @(negedge clk);
    cs = 1'b0; strobe = 1'b0; rd_nwr = 1'b0;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", rdata, 10'h000);
    acc(1'b1, 1'b1, 2'd0, 1'b1, 10'h000);
    check("R1", rdata, 10'h000);            // address zero
    acc(1'b1, 1'b1, 2'd3, 1'b1, 10'h000);
    check("R1", rdata, 10'h000);            // mode zero

    // R1: pointer starts at red: first writes after reset land at address 0
    acc(1'b1, 1'b1, 2'd1, 1'b0, 10'h0A1);
    acc(1'b1, 1'b1, 2'd1, 1'b0, 10'h0B2);
    acc(1'b1, 1'b1, 2'd1, 1'b0, 10'h0C3);
    acc(1'b1, 1'b1, 2'd0, 1'b1, 10'h000);
    check("R1", rdata, 10'h001);
    acc(1'b1, 1'b1, 2'd0, 1'b0, 10'h000);
    acc(1'b1, 1'b1, 2'd1, 1'b1, 10'h000);
    check("R1", rdata, 10'h0A1);

    for (int i = 0; i < NV; i++) begin
      acc(1'b1, 1'b1, VEC[i][22:21], VEC[i][20], VEC[i][19:10]);
      if (VEC[i][20]) begin
        checks++;
        if (rdata !== VEC[i][9:0]) begin
          fails++;
          $display("FAIL R%0d (vector %0d): got %h expected %h",
                   VEC[i][26:23], i, rdata, VEC[i][9:0]);
        end
      end
    end

    // R11: strobe without cs, and cs without strobe, are ignored
    acc(1'b1, 1'b1, 2'd0, 1'b0, 10'h040);
    acc(1'b0, 1'b1, 2'd0, 1'b0, 10'h055);
    acc(1'b1, 1'b0, 2'd0, 1'b0, 10'h066);
    acc(1'b0, 1'b1, 2'd3, 1'b0, 10'h001);
    acc(1'b1, 1'b1, 2'd0, 1'b1, 10'h000);
    check("R11", rdata, 10'h040);
    acc(1'b1, 1'b1, 2'd3, 1'b1, 10'h000);
    check("R11", rdata, 10'h000);
    // R11: ignored palette strobe leaves pointer at red
    acc(1'b1, 1'b1, 2'd0, 1'b0, 10'h010);
    acc(1'b0, 1'b1, 2'd1, 1'b1, 10'h000);
    acc(1'b1, 1'b1, 2'd1, 1'b1, 10'h000);
    check("R11", rdata, 10'h111);
    // R6: rdata holds across writes
    acc(1'b1, 1'b1, 2'd0, 1'b0, 10'h099);
    check("R6", rdata, 10'h111);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule